// File: doc/BRIEF.md
# Round-Robin Time-Shared Duplicate-and-Compare Checker

This block adds concurrent error detection to a group of small functional units while paying for only one checking datapath. A scheduler hands the single checker to one unit at a time and moves to the next unit after a fixed number of cycles, wrapping from the last unit back to the first. While a unit holds the checker, its input is copied into a duplicate model of that unit's function. The duplicate result is compared with the unit's real output once both have gone through the same pipeline latency.

The functional units always run at full rate. Checking only observes them, so their outputs are never delayed or held. For verification, each stand-in unit has a fault input that flips bit 0 of its output. A mismatch sets a sticky error flag and records which unit failed, and both hold until a clear pulse arrives. Each unit also has a saturating counter of dwell windows that finished with no mismatch.

The number of units, the data width, the unit latency, the dwell length and the counter width are parameters. A longer dwell costs nothing in area but delays detection. The duplicate model adds one copy of the unit function, not one per unit.

Top module: `tm_online_checker`

## Requirements
- R1: After reset `slot_id` is 0. It advances by one every DWELL cycles and wraps from N_UNITS-1 to 0. After the k-th rising clock edge following reset release (k counted from 0), `slot_id` equals floor((k+1)/DWELL) mod N_UNITS.
- R2: Unit i drives `unit_out[i*DATA_W +: DATA_W]` with (x*(2i+3)+i) mod 2^DATA_W, where x is the value of its `unit_in` slice LAT cycles earlier. `fault_mask[i]` combinationally inverts bit 0 of that output. The checker never affects these outputs.
- R3: A capture taken at clock edge k from the selected unit is compared with that unit's live output in the cycle after edge k+LAT-1. A mismatch sets `err_flag` from edge k+LAT on.
- R4: The first capture of each dwell window is discarded. A fault that is visible only during that capture's compare cycle raises no error and does not spoil the window.
- R5: A fault on a unit that is not the one tagged for the current compare raises no error.
- R6: `err_flag` is sticky. `err_unit` records the unit index of the mismatch that set the flag, and later mismatches do not change it.
- R7: A one-cycle `err_clear` sets `err_flag` and `err_unit` to 0 on the next edge. If a mismatch happens in the same cycle, the mismatch wins and its unit is recorded.
- R8: `pass_count[i*CNT_W +: CNT_W]` increments by one, LAT+1 cycles after the last capture of unit i's window, if no counted compare of that window mismatched. It saturates at 2^CNT_W-1.
- R9: During reset, `err_flag`, `err_unit`, every pass count and `slot_id` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| unit_in | input | N_UNITS*DATA_W | Packed inputs of the functional units, unit i at slice i |
| fault_mask | input | N_UNITS | Per-unit fault injection, inverts output bit 0 |
| err_clear | input | 1 | Pulse that clears the error flag and recorded unit |
| unit_out | output | N_UNITS*DATA_W | Packed live outputs of the functional units |
| slot_id | output | $clog2(N_UNITS) | Unit currently holding the checker |
| err_flag | output | 1 | Sticky mismatch flag |
| err_unit | output | $clog2(N_UNITS) | Index of the unit whose mismatch set the flag |
| pass_count | output | N_UNITS*CNT_W | Per-unit saturating counts of clean dwell windows |

## Verification
Every timed result is keyed to an edge counter that starts at reset release. A unit output is due LAT edges after its input. A capture at edge k is compared in the cycle after edge k+LAT-1, so its error is visible after edge k+LAT. A clean window shows in its pass count one edge after its last compare. The bench drives each fault for exactly one chosen compare cycle, or across a run of compare cycles that belong to a chosen unit. It then samples at a falling edge that the arithmetic places after the due edge and before the next window could change the same result.

// File: rtl/tmoc_pkg.sv
package tmoc_pkg;

    // Capture qualifiers that travel with each checker sample
    typedef struct packed {
        logic valid;  // counted compare
        logic first;  // first capture of a dwell window
        logic last;   // last capture of a dwell window
    } tmoc_flags_t;

    // Function shared by the stand-in units and the duplicate model
    function automatic logic [31:0] unit_fn(input logic [31:0] x, input int idx);
        return x * 32'(2 * idx + 3) + 32'(idx);
    endfunction

endpackage

// File: rtl/tmoc_unit.sv
module tmoc_unit #(
    parameter int DATA_W = 8,
    parameter int LAT    = 2,
    parameter int IDX    = 0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] x,
    input  logic              fault,
    output logic [DATA_W-1:0] y
);
    import tmoc_pkg::*;

    logic [DATA_W-1:0] pipe_d [LAT];
    logic [DATA_W-1:0] pipe_q [LAT];

    always_comb begin
        pipe_d[0] = DATA_W'(unit_fn(32'(x), IDX));
        for (int s = 1; s < LAT; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    // injected fault flips the least significant output bit
    assign y = pipe_q[LAT-1] ^ DATA_W'(fault);

endmodule

// File: rtl/tmoc_sched.sv
module tmoc_sched #(
    parameter int N_UNITS = 4,
    parameter int DWELL   = 4
) (
    input  logic                       clk,
    input  logic                       rst_n,
    output logic [$clog2(N_UNITS)-1:0] slot,
    output tmoc_pkg::tmoc_flags_t      flags
);
    localparam int SW  = $clog2(N_UNITS);
    localparam int DCW = $clog2(DWELL);
    localparam logic [SW-1:0]  LAST_SLOT = SW'(N_UNITS - 1);
    localparam logic [DCW-1:0] LAST_CNT  = DCW'(DWELL - 1);

    typedef struct packed {
        logic [SW-1:0]  slot;
        logic [DCW-1:0] cnt;
    } sched_t;

    sched_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == LAST_CNT) begin
            st_d.cnt  = '0;
            st_d.slot = (st_q.slot == LAST_SLOT) ? '0 : st_q.slot + 1'b1;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign slot        = st_q.slot;
    assign flags.first = (st_q.cnt == '0);
    assign flags.valid = (st_q.cnt != '0);
    assign flags.last  = (st_q.cnt == LAST_CNT);

endmodule

// File: rtl/tmoc_dup.sv
module tmoc_dup #(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 8,
    parameter int LAT     = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [DATA_W-1:0]          cap_x,
    input  logic [$clog2(N_UNITS)-1:0] cap_slot,
    input  tmoc_pkg::tmoc_flags_t      cap_flags,
    output logic [DATA_W-1:0]          dup_y,
    output logic [$clog2(N_UNITS)-1:0] tag_slot,
    output tmoc_pkg::tmoc_flags_t      tag_flags
);
    import tmoc_pkg::*;

    localparam int SW = $clog2(N_UNITS);

    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic [SW-1:0]     slot;
        tmoc_flags_t       flags;
    } stage_t;

    stage_t pipe_d [LAT];
    stage_t pipe_q [LAT];

    always_comb begin
        pipe_d[0].data  = DATA_W'(unit_fn(32'(cap_x), int'(cap_slot)));
        pipe_d[0].slot  = cap_slot;
        pipe_d[0].flags = cap_flags;
        for (int s = 1; s < LAT; s++) begin
            pipe_d[s] = pipe_q[s-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < LAT; s++) begin
                pipe_q[s] <= '0;
            end
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dup_y     = pipe_q[LAT-1].data;
    assign tag_slot  = pipe_q[LAT-1].slot;
    assign tag_flags = pipe_q[LAT-1].flags;

endmodule

// File: rtl/tm_online_checker.sv
module tm_online_checker #(
    parameter int N_UNITS = 4,
    parameter int DATA_W  = 8,
    parameter int LAT     = 2,
    parameter int DWELL   = 4,
    parameter int CNT_W   = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [N_UNITS*DATA_W-1:0]   unit_in,
    input  logic [N_UNITS-1:0]          fault_mask,
    input  logic                        err_clear,
    output logic [N_UNITS*DATA_W-1:0]   unit_out,
    output logic [$clog2(N_UNITS)-1:0]  slot_id,
    output logic                        err_flag,
    output logic [$clog2(N_UNITS)-1:0]  err_unit,
    output logic [N_UNITS*CNT_W-1:0]    pass_count
);
    import tmoc_pkg::*;

    localparam int SW = $clog2(N_UNITS);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    logic [DATA_W-1:0] x_arr [N_UNITS];
    logic [DATA_W-1:0] y_arr [N_UNITS];

    // functional units: always running, never held by the checker
    for (genvar g = 0; g < N_UNITS; g++) begin : g_unit
        assign x_arr[g] = unit_in[g*DATA_W +: DATA_W];
        tmoc_unit #(
            .DATA_W (DATA_W),
            .LAT    (LAT),
            .IDX    (g)
        ) u_unit (
            .clk   (clk),
            .rst_n (rst_n),
            .x     (x_arr[g]),
            .fault (fault_mask[g]),
            .y     (y_arr[g])
        );
        assign unit_out[g*DATA_W +: DATA_W] = y_arr[g];
    end

    // round-robin slot scheduler
    logic [SW-1:0] cap_slot;
    tmoc_flags_t   cap_flags;

    tmoc_sched #(
        .N_UNITS (N_UNITS),
        .DWELL   (DWELL)
    ) u_sched (
        .clk   (clk),
        .rst_n (rst_n),
        .slot  (cap_slot),
        .flags (cap_flags)
    );

    // input capture mux feeding the duplicate model
    logic [DATA_W-1:0] cap_x;
    assign cap_x = x_arr[cap_slot];

    logic [DATA_W-1:0] dup_y;
    logic [SW-1:0]     tag_slot;
    tmoc_flags_t       tag_flags;

    tmoc_dup #(
        .N_UNITS (N_UNITS),
        .DATA_W  (DATA_W),
        .LAT     (LAT)
    ) u_dup (
        .clk       (clk),
        .rst_n     (rst_n),
        .cap_x     (cap_x),
        .cap_slot  (cap_slot),
        .cap_flags (cap_flags),
        .dup_y     (dup_y),
        .tag_slot  (tag_slot),
        .tag_flags (tag_flags)
    );

    // output capture mux and comparison
    logic [DATA_W-1:0] live_y;
    logic              cmp_fail;
    assign live_y   = y_arr[tag_slot];
    assign cmp_fail = tag_flags.valid && (live_y != dup_y);

    // error reporting and per-unit pass tally
    typedef struct packed {
        logic                          flag;
        logic [SW-1:0]                 unit;
        logic                          win_bad;
        logic [N_UNITS-1:0][CNT_W-1:0] cnt;
    } rep_t;

    rep_t rep_d, rep_q;

    always_comb begin
        rep_d = rep_q;
        if (err_clear) begin
            rep_d.flag = 1'b0;
            rep_d.unit = '0;
        end
        if (cmp_fail && (!rep_q.flag || err_clear)) begin
            rep_d.flag = 1'b1;
            rep_d.unit = tag_slot;
        end
        if (tag_flags.first) begin
            rep_d.win_bad = 1'b0;
        end
        if (cmp_fail) begin
            rep_d.win_bad = 1'b1;
        end
        if (tag_flags.last && !rep_q.win_bad && !cmp_fail
            && (rep_q.cnt[tag_slot] != CNT_MAX)) begin
            rep_d.cnt[tag_slot] = rep_q.cnt[tag_slot] + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rep_q <= '0;
        end else begin
            rep_q <= rep_d;
        end
    end

    assign slot_id    = cap_slot;
    assign err_flag   = rep_q.flag;
    assign err_unit   = rep_q.unit;
    assign pass_count = rep_q.cnt;

endmodule

// File: rtl/tmoc_chk.sv
module tmoc_chk #(
    parameter int N_UNITS = 4,
    parameter int CNT_W   = 8
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic [$clog2(N_UNITS)-1:0] slot_id,
    input logic                       err_flag,
    input logic [$clog2(N_UNITS)-1:0] err_unit,
    input logic                       err_clear,
    input logic [N_UNITS*CNT_W-1:0]   pass_count,
    input logic                       cmp_fail,
    input logic                       cmp_first
);
    localparam int SW = $clog2(N_UNITS);
    localparam logic [SW-1:0] LAST_SLOT = SW'(N_UNITS - 1);

    // R1: slot moves only to its round-robin successor
    a_r1_slot_step: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_id != $past(slot_id)) |->
        (slot_id == (($past(slot_id) == LAST_SLOT) ? '0 : $past(slot_id) + 1'b1)));

    // R1: slot stays inside the unit range
    a_r1_slot_range: assert property (@(posedge clk) disable iff (!rst_n)
        slot_id <= LAST_SLOT);

    // R3: a counted mismatch raises the flag on the next edge
    a_r3_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_fail |=> err_flag);

    // R4: the first capture of a window never reports a mismatch
    a_r4_first_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_first |-> !cmp_fail);

    // R6: flag and recorded unit hold while no clear arrives
    a_r6_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !err_clear) |=> (err_flag && $stable(err_unit)));

    // R7: a clear with no concurrent mismatch drops the flag
    a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (err_clear && !cmp_fail) |=> (!err_flag && err_unit == '0));

    // R8: pass counts never decrease
    for (genvar g = 0; g < N_UNITS; g++) begin : g_cnt
        a_r8_no_decrease: assert property (@(posedge clk) disable iff (!rst_n)
            pass_count[g*CNT_W +: CNT_W] >= $past(pass_count[g*CNT_W +: CNT_W]));
    end

endmodule

bind tm_online_checker tmoc_chk #(
    .N_UNITS (N_UNITS),
    .CNT_W   (CNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_id    (slot_id),
    .err_flag   (err_flag),
    .err_unit   (err_unit),
    .err_clear  (err_clear),
    .pass_count (pass_count),
    .cmp_fail   (cmp_fail),
    .cmp_first  (tag_flags.first)
);

// File: tb/tm_online_checker_test.sv
`timescale 1ns/1ps
module tm_online_checker_test;
    localparam int N  = 4;
    localparam int W  = 8;
    localparam int L  = 2;
    localparam int D  = 4;
    localparam int CW = 8;
    localparam int ROT = N * D;

    logic           clk = 1'b0;
    logic           rst_n;
    logic [N*W-1:0] unit_in;
    logic [N-1:0]   fault_mask;
    logic           err_clear;
    logic [N*W-1:0] unit_out;
    logic [1:0]     slot_id;
    logic           err_flag;
    logic [1:0]     err_unit;
    logic [N*CW-1:0] pass_count;

    int checks = 0;
    int failures = 0;
    int edge_idx = 0;
    int hist [16][N];

    always #2 clk = ~clk;

    tm_online_checker #(
        .N_UNITS (N), .DATA_W (W), .LAT (L), .DWELL (D), .CNT_W (CW)
    ) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .unit_in    (unit_in),
        .fault_mask (fault_mask),
        .err_clear  (err_clear),
        .unit_out   (unit_out),
        .slot_id    (slot_id),
        .err_flag   (err_flag),
        .err_unit   (err_unit),
        .pass_count (pass_count)
    );

    always @(posedge clk) if (rst_n) edge_idx <= edge_idx + 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_f(input int x, input int i);
        return (x * (2 * i + 3) + i) % 256;
    endfunction

    function automatic int pc(input int i);
        return int'(pass_count[i*CW +: CW]);
    endfunction

    // wait for the falling edge that follows edge k (edges counted from 0)
    task automatic at_edge(input int k);
        while (edge_idx != k + 1) @(negedge clk);
    endtask

    // per-cycle datapath and schedule checks, plus input driving
    initial begin
        unit_in = '0;
        for (int a = 0; a < 16; a++) for (int b = 0; b < N; b++) hist[a][b] = 0;
        wait (rst_n === 1'b1);
        forever begin
            @(negedge clk);
            #1;
            chk(int'(slot_id) == (edge_idx / D) % N, "R1 slot order",
                int'(slot_id), (edge_idx / D) % N);
            if (edge_idx >= L + 2) begin
                for (int i = 0; i < N; i++) begin
                    int e;
                    e = exp_f(hist[(edge_idx - L) % 16][i], i) ^ int'(fault_mask[i]);
                    chk(int'(unit_out[i*W +: W]) == e, "R2 unit output",
                        int'(unit_out[i*W +: W]), e);
                end
            end
            for (int i = 0; i < N; i++) begin
                int v;
                v = (edge_idx * 7 + i * 29 + 3) % 256;
                hist[edge_idx % 16][i] = v;
                unit_in[i*W +: W] = W'(v);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", edge_idx, 4200);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        fault_mask = '0;
        err_clear = 1'b0;
        repeat (3) @(negedge clk);
        // R9 reset state
        chk(err_flag == 1'b0, "R9 flag", int'(err_flag), 0);
        chk(err_unit == 2'd0, "R9 unit", int'(err_unit), 0);
        chk(slot_id == 2'd0, "R9 slot", int'(slot_id), 0);
        for (int i = 0; i < N; i++) chk(pc(i) == 0, "R9 count", pc(i), 0);
        rst_n = 1'b1;

        // R8 two clean rotations
        at_edge(2 * ROT + L);
        chk(err_flag == 1'b0, "R3 no false error", int'(err_flag), 0);
        for (int i = 0; i < N; i++) chk(pc(i) == 2, "R8 clean windows", pc(i), 2);

        // R4 fault only on the compare of unit 1's first capture (edge 52)
        at_edge(53); fault_mask = 4'b0010;
        at_edge(54); fault_mask = '0;
        at_edge(58);
        chk(err_flag == 1'b0, "R4 first capture discarded", int'(err_flag), 0);
        chk(pc(1) == 4, "R4 window still counted", pc(1), 4);

        // R5 fault on unit 0 while unit 2 is being compared
        at_edge(73); fault_mask = 4'b0001;
        at_edge(76); fault_mask = '0;
        at_edge(78);
        chk(err_flag == 1'b0, "R5 unselected unit ignored", int'(err_flag), 0);

        // R3 fault on unit 3 second capture (edge 93), compared after edge 94
        at_edge(94); fault_mask = 4'b1000;
        at_edge(95); fault_mask = '0;
        chk(err_flag == 1'b1, "R3 flag set", int'(err_flag), 1);
        chk(err_unit == 2'd3, "R3 unit recorded", int'(err_unit), 3);
        at_edge(100);
        chk(pc(3) == 5, "R8 faulty window not counted", pc(3), 5);
        chk(pc(0) == 6, "R8 unit 0 count", pc(0), 6);
        chk(pc(2) == 6, "R8 unit 2 count", pc(2), 6);

        // R6 later mismatch on unit 1 keeps the first record
        at_edge(102); fault_mask = 4'b0010;
        at_edge(103); fault_mask = '0;
        at_edge(105);
        chk(err_flag == 1'b1, "R6 flag sticky", int'(err_flag), 1);
        chk(err_unit == 2'd3, "R6 unit kept", int'(err_unit), 3);

        // R7 clear
        at_edge(106); err_clear = 1'b1;
        at_edge(107); err_clear = 1'b0;
        chk(err_flag == 1'b0, "R7 flag cleared", int'(err_flag), 0);
        chk(err_unit == 2'd0, "R7 unit cleared", int'(err_unit), 0);

        // R3 new error on unit 0 (capture 129)
        at_edge(130); fault_mask = 4'b0001;
        at_edge(131); fault_mask = '0;
        chk(err_flag == 1'b1, "R3 flag set again", int'(err_flag), 1);
        chk(err_unit == 2'd0, "R3 unit 0 recorded", int'(err_unit), 0);

        // R7 clear and unit 2 mismatch (capture 137) in the same cycle
        at_edge(138); fault_mask = 4'b0100; err_clear = 1'b1;
        at_edge(139); fault_mask = '0; err_clear = 1'b0;
        chk(err_flag == 1'b1, "R7 mismatch beats clear", int'(err_flag), 1);
        chk(err_unit == 2'd2, "R7 new unit recorded", int'(err_unit), 2);

        // R8 saturation after more than 255 windows per unit
        at_edge(262 * ROT + L);
        for (int i = 0; i < N; i++) chk(pc(i) == 255, "R8 saturation", pc(i), 255);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule